// File: doc/BRIEF.md
# Bit-Serial GF(2^m) Multiply/Add Coprocessor

This block is a command-driven arithmetic engine for binary extension fields GF(2^m) with a field degree of up to 192. It keeps five 192-bit words: a multiplier operand `a`, a multiplicand `b`, a reduction polynomial `p`, an accumulator `r`, and a staging word that an external transfer engine fills and drains one byte at a time. Words move between the staging word and the arithmetic registers over an internal full-width path, each move started by a command.

A multiply walks the multiplier MSB first, one coefficient per cycle. In each step the accumulator is shifted left, the multiplicand is added if the current coefficient is 1, and the polynomial is added if the coefficient that was shifted out was 1. The overflow test always looks at bit 191, so every operand and the polynomial sit left-aligned in their words, and software does the alignment. The polynomial word holds `p` without its x^m term and can be any polynomial. The same XOR network performs field addition in a single step.

The staging word is separate from the arithmetic registers. Bytes can therefore stream in or out while a multiply runs. Software loads all three operands, clears the accumulator, issues the multiply, copies the accumulator to the staging word and shifts the result out.

Top module: `gf2m_coproc`

## Requirements
- R1: After reset `busy`, `done` and `rejected` are 0 and `io_dout` is 0x00.
- R2: While `io_shift` is 1 at a clock edge, the staging word shifts left by 8 and takes `io_din` into its low byte. `io_dout` always shows bits 191..184, so 24 shifts move a word in (or out) most significant byte first.
- R3: The move commands each keep `busy` high for 4 cycles. They are encoded on `cmd_op` as: 3 copies r to the staging word, 4 clears r, 5 loads b from the staging word, 6 loads a from the staging word, 7 loads p from the staging word.
- R4: Opcode 2 (add) sets r to r XOR b and keeps `busy` high for 4 cycles.
- R5: Opcode 1 (multiply) runs with r cleared beforehand and with a, b and p left-aligned for degree m. It leaves in r the left-aligned product a·b mod (x^m + p), and keeps `busy` high for m+4 cycles.
- R6: `deg_m` is sampled only in the cycle a multiply is accepted. A value of 0 or a value above 192 counts as 192. Later changes do not alter the running multiply.
- R7: `busy` rises on the edge that accepts a command. It stays high for exactly the length of that command. `done` is 1 for the single cycle right after `busy` falls.
- R8: A command presented while `busy` is 1 is ignored and has no effect on any register. `rejected` is 1 in the following cycle.
- R9: Opcode 0 is ignored. It neither raises `busy` nor changes any register.
- R10: Byte shifts of the staging word during a running multiply change neither the product nor the shifted-in data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised internally on release |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| deg_m | input | 8 | Field degree for a multiply |
| io_shift | input | 1 | Shift the staging word by one byte |
| io_din | input | 8 | Byte shifted into the staging word |
| io_dout | output | 8 | Top byte of the staging word |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse after a command completes |
| rejected | output | 1 | One-cycle pulse after a command arrived while busy |

## Verification
A command is accepted on one rising edge. `busy` is then seen high from the next sample point onward, so the bench counts falling-edge samples with `busy` high and compares that count with 4 or m+4. In the sample where `busy` is first low, the bench checks `done`. Because every result is observable only through the staging word, it is checked after a copy command finishes: one byte is sampled before each shift edge. A rejected command is checked one sample after the edge that saw it, and ignored commands are checked through the product or word read out afterward.

// File: rtl/gf2m_pkg.sv
package gf2m_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_MUL = 3'd1,
    OP_ADD = 3'd2,
    OP_IOR = 3'd3,
    OP_CLR = 3'd4,
    OP_LDB = 3'd5,
    OP_LDA = 3'd6,
    OP_LDP = 3'd7
  } gf_op_e;

  localparam int SHORT_LEN = 4;
  localparam int MUL_EXTRA = 4;
endpackage

// File: rtl/gf2m_rst_sync.sv
module gf2m_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/gf2m_ctrl.sv
module gf2m_ctrl
  import gf2m_pkg::*;
#(
  parameter int W = 192,
  localparam int CW = $clog2(W + MUL_EXTRA)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [CW-1:0] deg_m,
  output logic          busy,
  output logic          done,
  output logic          rejected,
  output logic          do_shift,
  output logic          do_add,
  output logic          do_clr,
  output logic          do_lda,
  output logic          do_ldb,
  output logic          do_ldp,
  output logic          do_ior
);
  gf_op_e        op_q, op_n, cmd_e;
  logic          busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] m_q, m_n, m_eff;
  logic          done_q, done_n, rej_q, rej_n;
  logic          accept, last;

  assign cmd_e  = gf_op_e'(cmd_op);
  assign accept = cmd_valid && !busy_q && (cmd_e != OP_NOP);
  assign last   = busy_q && (cnt_q == '0);

  always_comb begin
    if (deg_m == '0 || deg_m > CW'(W)) m_eff = CW'(W);
    else                               m_eff = deg_m;
  end

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    op_n   = op_q;
    m_n    = m_q;
    if (accept) begin
      busy_n = 1'b1;
      op_n   = cmd_e;
      m_n    = m_eff;
      cnt_n  = (cmd_e == OP_MUL) ? (m_eff + CW'(MUL_EXTRA - 1)) : CW'(SHORT_LEN - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_n = 1'b0;
      else             cnt_n  = cnt_q - 1'b1;
    end
    done_n = last;
    rej_n  = cmd_valid && busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_NOP;
      m_q    <= '0;
      done_q <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      op_q   <= op_n;
      m_q    <= m_n;
      done_q <= done_n;
      rej_q  <= rej_n;
    end
  end

  assign do_shift = busy_q && (op_q == OP_MUL) && (cnt_q != '0) && (cnt_q <= m_q);
  assign do_add   = last && (op_q == OP_ADD);
  assign do_clr   = last && (op_q == OP_CLR);
  assign do_lda   = last && (op_q == OP_LDA);
  assign do_ldb   = last && (op_q == OP_LDB);
  assign do_ldp   = last && (op_q == OP_LDP);
  assign do_ior   = last && (op_q == OP_IOR);

  assign busy     = busy_q;
  assign done     = done_q;
  assign rejected = rej_q;
endmodule

// File: rtl/gf2m_ioreg.sv
module gf2m_ioreg #(
  parameter int W  = 192,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_word,
  input  logic          shift,
  input  logic [BW-1:0] din,
  output logic [BW-1:0] dout,
  output logic [W-1:0]  word
);
  logic [W-1:0] io_q, io_n;
  logic         io_en;

  assign io_en = load || shift;

  always_comb begin
    if (load) io_n = load_word;
    else      io_n = {io_q[W-BW-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     io_q <= '0;
    else if (io_en) io_q <= io_n;
  end

  assign dout = io_q[W-1 -: BW];
  assign word = io_q;
endmodule

// File: rtl/gf2m_datapath.sv
module gf2m_datapath #(
  parameter int W = 192
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         do_shift,
  input  logic         do_add,
  input  logic         do_clr,
  input  logic         do_lda,
  input  logic         do_ldb,
  input  logic         do_ldp,
  input  logic [W-1:0] io_word,
  output logic [W-1:0] r_word
);
  logic [W-1:0] a_q, a_n, b_q, p_q, r_q, r_n, step;
  logic         a_en, r_en, mbit, reduce;

  assign mbit   = do_shift ? a_q[W-1] : 1'b1;
  assign reduce = do_shift && r_q[W-1];

  for (genvar gi = 0; gi < W; gi++) begin : g_cell
    logic low;
    if (gi == 0) begin : g_lsb
      assign low = 1'b0;
    end else begin : g_mid
      assign low = r_q[gi-1];
    end
    assign step[gi] = (do_shift ? (low ^ (reduce & p_q[gi])) : r_q[gi]) ^ (mbit & b_q[gi]);
  end

  assign r_en = do_shift || do_add || do_clr;
  assign r_n  = do_clr ? '0 : step;
  assign a_en = do_lda || do_shift;
  assign a_n  = do_lda ? io_word : {a_q[W-2:0], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      p_q <= '0;
      r_q <= '0;
    end else begin
      if (a_en)   a_q <= a_n;
      if (do_ldb) b_q <= io_word;
      if (do_ldp) p_q <= io_word;
      if (r_en)   r_q <= r_n;
    end
  end

  assign r_word = r_q;
endmodule

// File: rtl/gf2m_coproc.sv
module gf2m_coproc #(
  parameter int W  = 192,
  parameter int BW = 8,
  localparam int CW = $clog2(W + gf2m_pkg::MUL_EXTRA)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [CW-1:0] deg_m,
  input  logic          io_shift,
  input  logic [BW-1:0] io_din,
  output logic [BW-1:0] io_dout,
  output logic          busy,
  output logic          done,
  output logic          rejected
);
  logic         rst_n_sync;
  logic         do_shift, do_add, do_clr, do_lda, do_ldb, do_ldp, do_ior;
  logic [W-1:0] io_word, r_word;

  gf2m_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  gf2m_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_sync), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .deg_m(deg_m), .busy(busy), .done(done), .rejected(rejected),
    .do_shift(do_shift), .do_add(do_add), .do_clr(do_clr), .do_lda(do_lda),
    .do_ldb(do_ldb), .do_ldp(do_ldp), .do_ior(do_ior)
  );

  gf2m_ioreg #(.W(W), .BW(BW)) u_io (
    .clk(clk), .rst_n(rst_n_sync), .load(do_ior), .load_word(r_word),
    .shift(io_shift), .din(io_din), .dout(io_dout), .word(io_word)
  );

  gf2m_datapath #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n_sync), .do_shift(do_shift), .do_add(do_add),
    .do_clr(do_clr), .do_lda(do_lda), .do_ldb(do_ldb), .do_ldp(do_ldp),
    .io_word(io_word), .r_word(r_word)
  );
endmodule

// File: rtl/gf2m_coproc_chk.sv
module gf2m_coproc_chk #(
  parameter int W  = 192,
  parameter int BW = 8,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic [CW-1:0] deg_m,
  input logic          io_shift,
  input logic [BW-1:0] io_dout,
  input logic          busy,
  input logic          done,
  input logic          rejected
);
  logic [CW:0] len_q, exp_q;
  logic        acc;
  assign acc = cmd_valid && !busy && (cmd_op != 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      exp_q <= '0;
    end else if (acc) begin
      len_q <= '0;
      if (cmd_op == 3'd1)
        exp_q <= ((deg_m == '0 || deg_m > CW'(W)) ? (CW+1)'(W) : {1'b0, deg_m}) + (CW+1)'(4);
      else
        exp_q <= (CW+1)'(4);
    end else if (busy) begin
      len_q <= len_q + 1'b1;
    end
  end

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R7
  done_only_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  // R5
  cmd_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (len_q == exp_q));
  // R8
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |-> $past(cmd_valid && busy));
  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy);
  // R9
  nop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 3'd0) |=> !busy);
  // R2
  io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_shift && !busy) |=> $stable(io_dout));
endmodule

bind gf2m_coproc gf2m_coproc_chk #(.W(W), .BW(BW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .deg_m(deg_m), .io_shift(io_shift), .io_dout(io_dout), .busy(busy),
  .done(done), .rejected(rejected)
);

// File: tb/tb_gf2m_coproc.sv
module tb_gf2m_coproc;
  localparam int W = 192;
  typedef logic [W-1:0] word_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [2:0] cmd_op;
  logic [7:0] deg_m;
  logic       io_shift;
  logic [7:0] io_din;
  logic [7:0] io_dout;
  logic       busy, done, rejected;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  gf2m_coproc dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .deg_m(deg_m), .io_shift(io_shift), .io_din(io_din), .io_dout(io_dout),
    .busy(busy), .done(done), .rejected(rejected)
  );

  task automatic chk(input bit ok, input string req, input word_t act, input word_t exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  function automatic int eff_m(input int m);
    return (m == 0 || m > W) ? W : m;
  endfunction

  function automatic word_t mask_m(input int m);
    word_t mk = '1;
    return mk << (W - m);
  endfunction

  function automatic word_t rnd_word();
    word_t v;
    for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // independent reference: unaligned carry-less product, reduced top down
  function automatic word_t ref_mul(input word_t a, input word_t b, input word_t p, input int m);
    int sh = W - m;
    logic [2*W-1:0] prod = '0;
    logic [2*W-1:0] bu, pu;
    word_t au;
    au = a >> sh;
    bu = {{W{1'b0}}, b >> sh};
    pu = {{W{1'b0}}, p >> sh};
    for (int i = 0; i < W; i++) if (au[i]) prod ^= bu << i;
    for (int i = 2*W-1; i >= m; i--) begin
      if (prod[i]) begin
        prod[i] = 1'b0;
        prod ^= pu << (i - m);
      end
    end
    return prod[W-1:0] << sh;
  endfunction

  // shift a word in (MSB byte first) while capturing the old contents
  task automatic xfer(input word_t wr, output word_t rd);
    for (int i = 0; i < W / 8; i++) begin
      @(negedge clk);
      rd[W-1-8*i -: 8] = io_dout;
      io_shift = 1'b1;
      io_din   = wr[W-1-8*i -: 8];
    end
    @(negedge clk);
    io_shift = 1'b0;
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] m, input int exp_len, input string req);
    int n = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; deg_m = m;
    @(negedge clk);
    cmd_valid = 1'b0;
    deg_m = 8'd5;  // R6: changed after acceptance
    while (busy) begin
      n++;
      @(negedge clk);
    end
    chk(done == 1'b1, {req, " done pulse (R7)"}, word_t'(done), word_t'(1));
    chk(n == exp_len, {req, " busy length"}, word_t'(n), word_t'(exp_len));
  endtask

  task automatic load_reg(input word_t v, input logic [2:0] op, input string req);
    word_t junk;
    xfer(v, junk);
    run_cmd(op, 8'd0, 4, req);
  endtask

  task automatic read_r(output word_t v);
    word_t junk = '0;
    run_cmd(3'd3, 8'd0, 4, "R3 copy-out");
    xfer(junk, v);
  endtask

  task automatic mul_case(input int m_in, input word_t a, input word_t b, input word_t p, input string req);
    word_t got, exp;
    int m = eff_m(m_in);
    load_reg(a, 3'd6, "R3 load a");
    load_reg(b, 3'd5, "R3 load b");
    load_reg(p, 3'd7, "R3 load p");
    run_cmd(3'd4, 8'd0, 4, "R3 clear");
    run_cmd(3'd1, 8'(m_in), m + 4, req);
    read_r(got);
    exp = ref_mul(a, b, p, m);
    chk(got == exp, {req, " product"}, got, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: actual=hung expected=completion");
    summary();
  end

  initial begin
    word_t x, y, got, a, b, p;
    void'($urandom(32'h1A2B3C4D));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; deg_m = '0;
    io_shift = 1'b0; io_din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1
    chk(busy == 0, "R1 busy", word_t'(busy), 0);
    chk(done == 0, "R1 done", word_t'(done), 0);
    chk(rejected == 0, "R1 rejected", word_t'(rejected), 0);
    chk(io_dout == 0, "R1 io_dout", word_t'(io_dout), 0);

    // R2: shift a word in and back out
    x = rnd_word();
    xfer(x, got);
    xfer('0, got);
    chk(got == x, "R2 byte round trip", got, x);

    // R4: additions through the shared datapath
    x = rnd_word(); y = rnd_word();
    load_reg(x, 3'd5, "R3 load b");
    run_cmd(3'd4, 8'd0, 4, "R3 clear");
    read_r(got);
    chk(got == '0, "R3 clear result", got, '0);
    run_cmd(3'd2, 8'd0, 4, "R4 add");
    read_r(got);
    chk(got == x, "R4 add into zero", got, x);
    load_reg(y, 3'd5, "R3 load b");
    run_cmd(3'd2, 8'd0, 4, "R4 add");
    read_r(got);
    chk(got == (x ^ y), "R4 add sum", got, x ^ y);
    run_cmd(3'd2, 8'd0, 4, "R4 add");
    read_r(got);
    chk(got == x, "R4 add twice cancels", got, x);

    // R9: opcode 0 ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 0, "R9 nop no busy", word_t'(busy), 0);
    read_r(got);
    chk(got == x, "R9 nop no change", got, x);

    // R5 directed corners
    mul_case(1, word_t'(1) << (W-1), word_t'(1) << (W-1), word_t'(1) << (W-1), "R5 m=1");
    mul_case(192, word_t'(1) << (W-1), word_t'(1) << (W-1), word_t'(8'h87), "R5 x^191 squared");
    mul_case(163, rnd_word() & mask_m(163), rnd_word() & mask_m(163),
             (word_t'(8'hC9)) << (W-163), "R5 m=163");
    // R6: out-of-range degree
    mul_case(0, rnd_word(), rnd_word(), rnd_word(), "R6 m=0");
    mul_case(200, rnd_word(), rnd_word(), rnd_word(), "R6 m=200");

    // R5 random
    for (int k = 0; k < 16; k++) begin
      int m = 1 + ($urandom % W);
      if (k == 0) m = 191;
      mul_case(m, rnd_word() & mask_m(m), rnd_word() & mask_m(m), rnd_word() & mask_m(m), "R5 random");
    end

    // R8, R10: reject while busy, stream bytes during a multiply
    a = rnd_word(); b = rnd_word(); p = rnd_word(); y = rnd_word();
    load_reg(a, 3'd6, "R3 load a");
    load_reg(b, 3'd5, "R3 load b");
    load_reg(p, 3'd7, "R3 load p");
    run_cmd(3'd4, 8'd0, 4, "R3 clear");
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd1; deg_m = 8'd192;
    @(negedge clk);
    cmd_op = 3'd4;  // clear while busy: must be dropped
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(rejected == 1, "R8 rejected pulse", word_t'(rejected), 1);
    xfer(y, got);
    chk(busy == 1, "R10 still busy during transfer", word_t'(busy), 1);
    while (busy) @(negedge clk);
    xfer('0, got);
    chk(got == y, "R10 staged word intact", got, y);
    read_r(got);
    chk(got == ref_mul(a, b, p, W), "R8 R10 product intact", got, ref_mul(a, b, p, W));

    summary();
  end
endmodule